// File: doc/BRIEF.md
# Serial Status Flag Register

This block holds the event flags of an asynchronous serial port. The transmit and receive engines report events to it as single-cycle strobes: a character moved into the transmit shifter, the last bit of a character sent, a character received (with its stop bit, parity bit, data and multiprocessor bit), and DMA accesses to the data registers. The CPU reads all flags as one byte at a single address. It clears an error or data flag by reading it as 1 and then writing 0 to it.

The flags drive two interrupt request levels. The transmit request is raised while the transmit data register is empty. The receive request is raised while received data is waiting or any receive error is latched. The register also holds a freely writable multiprocessor bit for the transmitter. It captures the multiprocessor bit of each received character.

Top module: `ser_stat_reg`

## Requirements
- R1: The byte read on `busRdata` is, from bit 7 down to bit 0: txEmpty, rxFull, overrun, framing, parity, txEnd, rxMp, mpTx.
- R2: After reset the byte reads 8'h84: txEmpty and txEnd are 1 and every other bit is 0.
- R3: The five flags in bits 7..3 clear from the bus only by a write with that bit 0, which follows a read that returned the flag as 1. Writing 1 leaves the flag unchanged. Any write consumes the read arming. A flag that clears by another path loses its arming.
- R4: txEmpty sets while `txEnable` is 0 or on `txLoadStb`. It clears on `dmaTxWrStb`.
- R5: rxFull sets when a received character has no framing error, no parity error and no overrun. It clears on `dmaRxRdStb`.
- R6: overrun sets when `rxDoneStb` arrives while rxFull is 1. rxFull stays 1.
- R7: framing sets when `rxDoneStb` arrives with `rxStopBit` 0.
- R8: With `parityEn` 1, parity sets when the XOR of `rxData` and `rxParityBit` differs from `parityOdd` (0 selects even, 1 selects odd). With `parityEn` 0, parity never sets.
- R9: txEnd is read-only. It sets while `txEnable` is 0, or on `txLastBitStb` while txEmpty is 1. It clears whenever txEmpty is cleared by the bus or by DMA.
- R10: rxMp takes `rxMpBit` on every `rxDoneStb` and ignores bus writes. mpTx (bit 0) takes bit 0 of every bus write and drives `mpTxBit`.
- R11: When a set event and a clear request hit the same flag in one cycle, the flag ends at 1.
- R12: `txIrq` equals txEmpty. `rxIrq` equals rxFull OR overrun OR framing OR parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register selected by the CPU bus |
| busRd | input | 1 | Bus read strobe |
| busWr | input | 1 | Bus write strobe |
| busWdata | input | 8 | Bus write data |
| busRdata | output | 8 | Flag byte |
| txEnable | input | 1 | Transmitter enable level |
| txLoadStb | input | 1 | Transmit data moved into the shifter |
| txLastBitStb | input | 1 | Last bit of a character being sent |
| dmaTxWrStb | input | 1 | DMA wrote the transmit data register |
| rxDoneStb | input | 1 | A character reception completed |
| rxData | input | DATA_W | Received data bits |
| rxParityBit | input | 1 | Received parity bit |
| rxStopBit | input | 1 | Sampled stop bit |
| rxMpBit | input | 1 | Received multiprocessor bit |
| parityEn | input | 1 | Parity checking enabled |
| parityOdd | input | 1 | 1 = odd parity, 0 = even |
| dmaRxRdStb | input | 1 | DMA read the receive data register |
| txEmpty | output | 1 | Transmit data register empty flag |
| rxFull | output | 1 | Receive data register full flag |
| errOverrun | output | 1 | Overrun error flag |
| errFraming | output | 1 | Framing error flag |
| errParity | output | 1 | Parity error flag |
| txEnd | output | 1 | Transmit end flag |
| rxMp | output | 1 | Last received multiprocessor bit |
| mpTxBit | output | 1 | Multiprocessor bit for transmission |
| txIrq | output | 1 | Transmit interrupt request |
| rxIrq | output | 1 | Receive interrupt request |

## Verification
Every flag is a register, so any strobe or bus write shows up on the outputs one clock edge after the cycle in which it is presented. `busRdata` and the interrupt levels follow the flags combinationally, so they change in that same edge. The bench drives every input on the falling edge and holds it for exactly one cycle. It samples at the next falling edge, which is the first point after the single register stage. A read arms a flag at the edge that ends the read cycle, so a clearing write is issued in a later cycle. The receive sweep covers all data values, both parity bits, both parity senses and both stop-bit values, and it predicts the flags from parity arithmetic done in the bench.

// File: rtl/ser_stat_pkg.sv
package ser_stat_pkg;
  localparam int NUM_CLR = 5;
  // index into the clearable-flag vector (vector bit i sits at byte bit i+CLR_LSB)
  localparam int IX_TXE = 4;
  localparam int IX_RXF = 3;
  localparam int IX_OVR = 2;
  localparam int IX_FRM = 1;
  localparam int IX_PAR = 0;
  localparam int CLR_LSB = 3;
  localparam int BIT_TEND = 2;
  localparam int BIT_RMP = 1;
  localparam int BIT_TMP = 0;
  localparam logic [NUM_CLR-1:0] CLR_RST = 5'b10000;

  typedef struct packed {
    logic [NUM_CLR-1:0] clr;
    logic mpWrEn;
    logic mpWrVal;
  } ctlStrobe_t;
endpackage

// File: rtl/ser_stat_ctl.sv
module ser_stat_ctl
  import ser_stat_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busRd,
  input  logic               busWr,
  input  logic [7:0]         busWdata,
  input  logic [NUM_CLR-1:0] flagVec,
  input  logic               dmaTxWrStb,
  input  logic               dmaRxRdStb,
  output ctlStrobe_t         strobes
);
  logic rdAcc, wrAcc;
  logic [NUM_CLR-1:0] armQ;
  logic [NUM_CLR-1:0] busClr;
  logic [NUM_CLR-1:0] dmaClr;

  assign rdAcc = busSel && busRd;
  assign wrAcc = busSel && busWr;

  for (genvar i = 0; i < NUM_CLR; i++) begin : g_arm
    always_ff @(posedge clk) begin
      if (!rstN)            armQ[i] <= 1'b0;
      else if (!flagVec[i]) armQ[i] <= 1'b0;   // flag low: arming gone
      else if (wrAcc)       armQ[i] <= 1'b0;   // any write consumes it
      else if (rdAcc)       armQ[i] <= 1'b1;   // read returned a 1
    end
    assign busClr[i] = wrAcc && armQ[i] && flagVec[i] && !busWdata[CLR_LSB+i];

    // R3: arming only ever comes from a read that saw the flag high
    a_r3_arm_from_read: assert property (@(posedge clk) disable iff (!rstN)
      $rose(armQ[i]) |-> $past(rdAcc && flagVec[i]));
  end

  always_comb begin
    dmaClr = '0;
    dmaClr[IX_TXE] = dmaTxWrStb;
    dmaClr[IX_RXF] = dmaRxRdStb;
  end

  always_comb begin
    strobes.clr     = busClr | dmaClr;
    strobes.mpWrEn  = wrAcc;
    strobes.mpWrVal = busWdata[BIT_TMP];
  end
endmodule

// File: rtl/ser_stat_dp.sv
module ser_stat_dp
  import ser_stat_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strobes,
  input  logic               txEnable,
  input  logic               txLoadStb,
  input  logic               txLastBitStb,
  input  logic               rxDoneStb,
  input  logic [DATA_W-1:0]  rxData,
  input  logic               rxParityBit,
  input  logic               rxStopBit,
  input  logic               rxMpBit,
  input  logic               parityEn,
  input  logic               parityOdd,
  output logic [NUM_CLR-1:0] flagVec,
  output logic               tendQ,
  output logic               rmpQ,
  output logic               tmpQ
);
  logic [NUM_CLR-1:0] setVec;
  logic frameBad, parityBad, cleanRx;

  assign frameBad  = !rxStopBit;
  assign parityBad = parityEn && ((^rxData ^ rxParityBit) != parityOdd);
  assign cleanRx   = !frameBad && !parityBad && !flagVec[IX_RXF];

  always_comb begin
    setVec         = '0;
    setVec[IX_TXE] = !txEnable || txLoadStb;
    setVec[IX_RXF] = rxDoneStb && cleanRx;
    setVec[IX_OVR] = rxDoneStb && flagVec[IX_RXF];
    setVec[IX_FRM] = rxDoneStb && frameBad;
    setVec[IX_PAR] = rxDoneStb && parityBad;
  end

  for (genvar i = 0; i < NUM_CLR; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN)                flagVec[i] <= CLR_RST[i];
      else if (setVec[i])       flagVec[i] <= 1'b1;   // set beats clear
      else if (strobes.clr[i])  flagVec[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                          tendQ <= 1'b1;
    else if (!txEnable || (txLastBitStb && flagVec[IX_TXE])) tendQ <= 1'b1;
    else if (strobes.clr[IX_TXE])                       tendQ <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rmpQ <= 1'b0;
      tmpQ <= 1'b0;
    end else begin
      if (rxDoneStb)      rmpQ <= rxMpBit;
      if (strobes.mpWrEn) tmpQ <= strobes.mpWrVal;
    end
  end

  a_r4_disable_sets_empty: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable |=> flagVec[IX_TXE] && tendQ);
  a_r11_load_beats_clear: assert property (@(posedge clk) disable iff (!rstN)
    txLoadStb |=> flagVec[IX_TXE]);
  a_r6_overrun_sets: assert property (@(posedge clk) disable iff (!rstN)
    (rxDoneStb && flagVec[IX_RXF]) |=> flagVec[IX_OVR] && flagVec[IX_RXF]);
  a_r7_framing_sets: assert property (@(posedge clk) disable iff (!rstN)
    (rxDoneStb && !rxStopBit) |=> flagVec[IX_FRM]);
  a_r8_no_parity_when_off: assert property (@(posedge clk) disable iff (!rstN)
    (!parityEn && !flagVec[IX_PAR]) |=> !flagVec[IX_PAR]);
endmodule

// File: rtl/ser_stat_reg.sv
module ser_stat_reg
  import ser_stat_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  input  logic              txEnable,
  input  logic              txLoadStb,
  input  logic              txLastBitStb,
  input  logic              dmaTxWrStb,
  input  logic              rxDoneStb,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxParityBit,
  input  logic              rxStopBit,
  input  logic              rxMpBit,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              dmaRxRdStb,
  output logic              txEmpty,
  output logic              rxFull,
  output logic              errOverrun,
  output logic              errFraming,
  output logic              errParity,
  output logic              txEnd,
  output logic              rxMp,
  output logic              mpTxBit,
  output logic              txIrq,
  output logic              rxIrq
);
  ctlStrobe_t         strobes;
  logic [NUM_CLR-1:0] flagVec;
  logic               tendQ, rmpQ, tmpQ;

  ser_stat_ctl u_ctl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .flagVec(flagVec), .dmaTxWrStb(dmaTxWrStb),
    .dmaRxRdStb(dmaRxRdStb), .strobes(strobes)
  );

  ser_stat_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .txEnable(txEnable),
    .txLoadStb(txLoadStb), .txLastBitStb(txLastBitStb), .rxDoneStb(rxDoneStb),
    .rxData(rxData), .rxParityBit(rxParityBit), .rxStopBit(rxStopBit),
    .rxMpBit(rxMpBit), .parityEn(parityEn), .parityOdd(parityOdd),
    .flagVec(flagVec), .tendQ(tendQ), .rmpQ(rmpQ), .tmpQ(tmpQ)
  );

  assign txEmpty    = flagVec[IX_TXE];
  assign rxFull     = flagVec[IX_RXF];
  assign errOverrun = flagVec[IX_OVR];
  assign errFraming = flagVec[IX_FRM];
  assign errParity  = flagVec[IX_PAR];
  assign txEnd      = tendQ;
  assign rxMp       = rmpQ;
  assign mpTxBit    = tmpQ;
  assign busRdata   = {flagVec, tendQ, rmpQ, tmpQ};
  assign txIrq      = flagVec[IX_TXE];
  assign rxIrq      = |flagVec[IX_RXF:IX_PAR];

  // R10: writes to the read-only positions do not reach rxMp
  a_r10_rmp_read_only: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && !rxDoneStb && (busWdata[BIT_TEND:BIT_RMP] != {tendQ, rmpQ}))
      |=> $stable(rxMp));
  // R3: a write with the parity bit set never clears it
  a_r3_one_write_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busWdata[CLR_LSB+IX_PAR] && errParity) |=> errParity);
  // R9: txEnd never rises without its set condition
  a_r9_tend_rise_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txEnd) |-> $past(!txEnable || (txLastBitStb && txEmpty)));
endmodule

// File: tb/ser_stat_reg_bench.sv
module ser_stat_reg_bench;
  logic clk = 0;
  logic rstN = 0;
  logic busSel = 0, busRd = 0, busWr = 0;
  logic [7:0] busWdata = 0, busRdata;
  logic txEnable = 1, txLoadStb = 0, txLastBitStb = 0, dmaTxWrStb = 0;
  logic rxDoneStb = 0, rxParityBit = 0, rxStopBit = 1, rxMpBit = 0;
  logic [7:0] rxData = 0;
  logic parityEn = 1, parityOdd = 0, dmaRxRdStb = 0;
  logic txEmpty, rxFull, errOverrun, errFraming, errParity, txEnd, rxMp, mpTxBit, txIrq, rxIrq;
  int checks = 0, errors = 0;
  logic [7:0] rv;

  always #2.5 clk = ~clk;

  ser_stat_reg u_ser_stat_reg (.*);

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busRead(output logic [7:0] v);
    busSel = 1; busRd = 1; #1 v = busRdata;
    step(); busSel = 0; busRd = 0;
  endtask

  task automatic busWrite(input logic [7:0] v);
    busSel = 1; busWr = 1; busWdata = v;
    step(); busSel = 0; busWr = 0;
  endtask

  task automatic receive(input logic [7:0] d, input logic p, input logic s, input logic m);
    rxData = d; rxParityBit = p; rxStopBit = s; rxMpBit = m; rxDoneStb = 1;
    step(); rxDoneStb = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(); step(); rstN = 1; step();
    check("R2 reset byte", busRdata, 8'h84);
    check("R12 irq after reset", {6'b0, txIrq, rxIrq}, 8'h02);

    // R3: write 0 without prior read keeps txEmpty
    busWrite(8'h00); step();
    check("R3 unarmed write", busRdata, 8'h84);
    busRead(rv); check("R1 read byte", rv, 8'h84);
    busWrite(8'hFE); step();
    check("R3 write one keeps", busRdata, 8'h84);
    busWrite(8'h00); step();
    check("R3 arming consumed", busRdata, 8'h84);
    busRead(rv); busWrite(8'h00); step();
    check("R3 R9 read then write 0 clears", busRdata, 8'h00);

    // R4
    txLoadStb = 1; step(); txLoadStb = 0;
    check("R4 load sets empty", busRdata, 8'h80);
    dmaTxWrStb = 1; step(); dmaTxWrStb = 0;
    check("R4 dma write clears", busRdata, 8'h00);

    // R9
    txLastBitStb = 1; step(); txLastBitStb = 0;
    check("R9 last bit with empty 0", busRdata, 8'h00);
    txLoadStb = 1; step(); txLoadStb = 0;
    txLastBitStb = 1; step(); txLastBitStb = 0;
    check("R9 last bit with empty 1", busRdata, 8'h84);
    dmaTxWrStb = 1; step(); dmaTxWrStb = 0;
    check("R9 dma clears end too", busRdata, 8'h00);
    txEnable = 0; step(); txEnable = 1;
    check("R4 R9 disable sets", busRdata, 8'h84);

    // R11
    busRead(rv);
    busSel = 1; busWr = 1; busWdata = 8'h00; txLoadStb = 1;
    step(); busSel = 0; busWr = 0; txLoadStb = 0;
    check("R11 load beats bus clear", busRdata, 8'h80);
    dmaTxWrStb = 1; txLoadStb = 1; step(); dmaTxWrStb = 0; txLoadStb = 0;
    check("R11 load beats dma clear", busRdata, 8'h80);

    // R10
    busWrite(8'h81); step();
    check("R10 mpTx written", {7'b0, mpTxBit}, 8'h01);
    check("R10 byte with mpTx", busRdata, 8'h81);
    receive(8'h00, 1'b0, 1'b1, 1'b1);
    check("R10 R5 rxMp captured", busRdata, 8'hC3);
    busWrite(8'hC1); step();
    check("R10 rxMp read-only", busRdata, 8'hC3);
    dmaRxRdStb = 1; step(); dmaRxRdStb = 0;
    check("R5 dma read clears", busRdata, 8'h83);

    // sweep receive combinations, transmitter held disabled
    txEnable = 0; parityEn = 1;
    for (int s = 0; s < 2; s++)
      for (int o = 0; o < 2; o++)
        for (int p = 0; p < 2; p++)
          for (int d = 0; d < 256; d++) begin
            logic [7:0] db;
            logic eFer, ePer, eRdrf;
            db = 8'(d);
            parityOdd = 1'(o);
            receive(db, 1'(p), 1'(s), db[0]);
            eFer = (s == 0);
            ePer = ((^db) ^ 1'(p)) != 1'(o);
            eRdrf = !eFer && !ePer;
            check("R5 R7 R8 R10 rx sweep", busRdata,
                  {1'b1, eRdrf, 1'b0, eFer, ePer, 1'b1, db[0], 1'b1});
            check("R12 rx irq", {6'b0, txIrq, rxIrq}, {6'b0, 1'b1, eRdrf | eFer | ePer});
            if (eRdrf) begin dmaRxRdStb = 1; step(); dmaRxRdStb = 0; end
            if (eFer || ePer) begin busRead(rv); busWrite(8'h81); end
          end
    txEnable = 1;
    step();
    check("R3 errors cleared", busRdata & 8'h7D, 8'h05);

    // R8 parity disabled
    parityEn = 0; parityOdd = 0;
    receive(8'h01, 1'b0, 1'b1, 1'b0);
    check("R8 parity off", busRdata, 8'hC5);

    // R6 overrun
    receive(8'h02, 1'b1, 1'b1, 1'b0);
    check("R6 overrun sets", busRdata, 8'hE5);
    busRead(rv); busWrite(8'hC1); step();
    check("R3 R6 overrun cleared, full kept", busRdata, 8'hC5);
    dmaRxRdStb = 1; step(); dmaRxRdStb = 0;
    check("R5 full cleared", busRdata, 8'h85);
    check("R12 rx irq idle", {7'b0, rxIrq}, 8'h00);

    // R3 arming lost when flag clears by DMA
    receive(8'h00, 1'b0, 1'b1, 1'b0);
    busRead(rv);
    dmaRxRdStb = 1; step(); dmaRxRdStb = 0;
    receive(8'h00, 1'b0, 1'b1, 1'b0);
    busWrite(8'h81); step();
    check("R3 arming reset by dma clear", busRdata, 8'hC5);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule